// File: doc/BRIEF.md
# Shadow RAM Attribute Decoder

This block holds the routing attributes for the upper memory area of a 20-bit host address space, from C0000h to FFFFFh. Firmware programs seven byte-wide configuration registers. For every host memory access the block then decides whether that read or write is served by internal DRAM (shadow RAM) or forwarded to the expansion bus.

The option-ROM window C0000h–EFFFFh is split into twelve 16 KB pieces, each with its own 4-bit attribute nibble. The system BIOS window F0000h–FFFFFh is one 64 KB piece controlled by a single nibble. In each nibble the read route and the write route are independent bits. This lets firmware copy ROM into RAM (reads go to the bus, writes go to RAM) and then run from RAM (reads go to RAM, writes go to the bus).

The routing decision is combinational from the access address and the current register contents. A register write affects accesses from the next clock onward. The block also drives a shadow-BIOS flag for the rest of the chip.

Top module: `shadow_attr_decoder`

## Requirements
- R1: The seven attribute registers sit at configuration offsets 59h to 5Fh. `cfg_rdata` returns the stored contents of the register at `cfg_addr`. Any other offset reads 00h, and writes to any other offset change neither the stored state nor the routing.
- R2: Register 59h stores only its upper nibble, which controls F0000h–FFFFFh. Bits 3:0 of that register are discarded on write and always read back as 0.
- R3: Register 5Ah+n (n = 0..5) covers two 16 KB segments. Bits 3:0 control segment 2n and bits 7:4 control segment 2n+1. Segment s spans C0000h + s·4000h up to that value + 3FFFh.
- R4: For a valid access in C0000h–FFFFFh, the selected nibble's bit 0 (for reads) or bit 1 (for writes) gives the route. A 1 asserts `route_internal` only; a 0 asserts `route_external` only. Exactly one of the two outputs is high.
- R5: `shadow_bios` equals bit 4 of register 59h.
- R6: Reset (active-low `rst_n`) clears all seven registers. Afterwards every register reads 00h, `shadow_bios` is 0, and every decoded access routes externally.
- R7: When `host_valid` is low, or the address is below C0000h, both route outputs are 0.
- R8: A register written at one rising clock edge affects routing and readback right after that edge, and not before it. Between writes, the route outputs follow the host address and direction combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration readback of the register at `cfg_addr` |
| host_valid | input | 1 | Host memory access present |
| host_write | input | 1 | 1 = write access, 0 = read access |
| host_addr | input | 20 | Host memory byte address |
| route_internal | output | 1 | Access is served by internal DRAM |
| route_external | output | 1 | Access is forwarded to the expansion bus |
| shadow_bios | output | 1 | BIOS region shadow flag |

## Verification
A corrupted attribute nibble appears on the route outputs in the same cycle that an access hits its segment. A missing or misplaced write appears in the cycle right after the write edge. The bench therefore sweeps both ends of every segment in both directions after each programming step, so a wrong nibble-to-segment mapping or a swapped read/write bit cannot hide. Readback at every offset exposes state stored in the wrong register, or kept where it should be dropped, without waiting for an access.

// File: rtl/shadow_attr_pkg.sv
package shadow_attr_pkg;

    typedef logic [3:0] attr_nib_t;

    // bit 0 routes reads, bit 1 routes writes; 1 = internal DRAM
    function automatic logic attr_pick(attr_nib_t nib, logic is_wr);
        return is_wr ? nib[1] : nib[0];
    endfunction

endpackage

// File: rtl/shadow_attr_regs.sv
module shadow_attr_regs
    import shadow_attr_pkg::*;
#(
    parameter logic [7:0] BASE_OFF = 8'h59,
    parameter int         OPT_SEGS = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [7:0]                wr_addr,
    input  logic [7:0]                wr_data,
    input  logic [7:0]                rd_addr,
    output logic [7:0]                rd_data,
    output attr_nib_t                 bios_attr,
    output logic [OPT_SEGS-1:0][3:0]  opt_attr
);
    localparam int NUM_REGS = 1 + OPT_SEGS / 2;

    typedef struct packed {
        attr_nib_t               bios;
        logic [OPT_SEGS-1:0][3:0] opt;
    } attr_st_t;

    attr_st_t   st_d, st_q;
    logic [7:0] wr_rel, rd_rel;

    always_comb begin
        st_d   = st_q;
        wr_rel = wr_addr - BASE_OFF;
        if (wr_en) begin
            if (wr_rel == 8'd0)
                st_d.bios = wr_data[7:4];
            for (int k = 1; k < NUM_REGS; k++) begin
                if (wr_rel == 8'(k)) begin
                    st_d.opt[2*k-2] = wr_data[3:0];
                    st_d.opt[2*k-1] = wr_data[7:4];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_rel  = rd_addr - BASE_OFF;
        rd_data = 8'h00;
        if (rd_rel == 8'd0)
            rd_data = {st_q.bios, 4'h0};
        for (int k = 1; k < NUM_REGS; k++) begin
            if (rd_rel == 8'(k))
                rd_data = {st_q.opt[2*k-1], st_q.opt[2*k-2]};
        end
    end

    assign bios_attr = st_q.bios;
    assign opt_attr  = st_q.opt;

    // R6: registers come out of reset cleared
    a_r6_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (st_q == '0));

    // R1: a write to an unmapped offset leaves stored state untouched
    a_r1_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_rel >= 8'(NUM_REGS))) |=> $stable(st_q));

endmodule

// File: rtl/shadow_route_sel.sv
module shadow_route_sel
    import shadow_attr_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int OPT_SEGS = 12
) (
    input  logic                      acc_valid,
    input  logic                      acc_write,
    input  logic [ADDR_W-1:0]         acc_addr,
    input  attr_nib_t                 bios_attr,
    input  logic [OPT_SEGS-1:0][3:0]  opt_attr,
    output logic                      to_internal,
    output logic                      to_external
);
    // the upper quarter of the space is decoded, in 16 KB granules
    localparam int IDX_W   = 4;
    localparam int IDX_LSB = ADDR_W - 2 - IDX_W;

    logic             in_upper;
    logic [IDX_W-1:0] seg_idx;
    attr_nib_t        nib;
    logic             hit_int;

    always_comb begin
        in_upper = (acc_addr[ADDR_W-1 -: 2] == 2'b11);
        seg_idx  = acc_addr[IDX_LSB +: IDX_W];
        nib      = bios_attr;
        for (int s = 0; s < OPT_SEGS; s++) begin
            if (seg_idx == IDX_W'(s))
                nib = opt_attr[s];
        end
        hit_int     = attr_pick(nib, acc_write);
        to_internal = acc_valid && in_upper && hit_int;
        to_external = acc_valid && in_upper && !hit_int;
    end

endmodule

// File: rtl/shadow_attr_decoder.sv
module shadow_attr_decoder
    import shadow_attr_pkg::*;
#(
    parameter int         ADDR_W   = 20,
    parameter int         OPT_SEGS = 12,
    parameter logic [7:0] BASE_OFF = 8'h59
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    output logic              route_internal,
    output logic              route_external,
    output logic              shadow_bios
);
    localparam logic [ADDR_W-1:0] DEC_START = {2'b11, {(ADDR_W-2){1'b0}}};

    attr_nib_t                bios_attr;
    logic [OPT_SEGS-1:0][3:0] opt_attr;

    shadow_attr_regs #(.BASE_OFF(BASE_OFF), .OPT_SEGS(OPT_SEGS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr),
        .wr_addr   (cfg_addr),
        .wr_data   (cfg_wdata),
        .rd_addr   (cfg_addr),
        .rd_data   (cfg_rdata),
        .bios_attr (bios_attr),
        .opt_attr  (opt_attr)
    );

    shadow_route_sel #(.ADDR_W(ADDR_W), .OPT_SEGS(OPT_SEGS)) u_sel (
        .acc_valid   (host_valid),
        .acc_write   (host_write),
        .acc_addr    (host_addr),
        .bios_attr   (bios_attr),
        .opt_attr    (opt_attr),
        .to_internal (route_internal),
        .to_external (route_external)
    );

    // shadow flag is bit 4 of the first register, i.e. the BIOS read bit
    assign shadow_bios = bios_attr[0];

    // R4: the two routes never both assert
    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(route_internal && route_external));

    // R4: a decoded access always picks exactly one route
    a_r4_decoded_one: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_addr >= DEC_START) |-> $onehot({route_internal, route_external}));

    // R7: nothing routed below the window or without a valid access
    a_r7_outside_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_valid || host_addr < DEC_START) |-> !(route_internal || route_external));

    // R2: the BIOS register low nibble always reads as zero
    a_r2_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == BASE_OFF) |-> (cfg_rdata[3:0] == 4'h0));

    // R5, R8: a BIOS register write shows on the flag after the edge
    a_r8_flag_next: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == BASE_OFF) |=> (shadow_bios == $past(cfg_wdata[4])));

endmodule

// File: tb/shadow_attr_decoder_tb.sv
module shadow_attr_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        host_valid = 1'b0;
    logic        host_write = 1'b0;
    logic [19:0] host_addr = 20'h0;
    logic        route_internal, route_external, shadow_bios;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] mdl [7];

    always #2 clk = ~clk;

    shadow_attr_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .host_valid(host_valid),
        .host_write(host_write), .host_addr(host_addr),
        .route_internal(route_internal), .route_external(route_external),
        .shadow_bios(shadow_bios)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_route(input logic v, input logic wr, input logic [19:0] a);
        logic [3:0] nib;
        int seg, r;
        if (!v || a < 20'hC0000) return 2'b00;
        if (a >= 20'hF0000) nib = mdl[0][7:4];
        else begin
            seg = int'((a - 20'hC0000) >> 14);
            r   = 1 + seg / 2;
            nib = (seg % 2 == 1) ? mdl[r][7:4] : mdl[r][3:0];
        end
        return (wr ? nib[1] : nib[0]) ? 2'b10 : 2'b01;
    endfunction

    task automatic cfg_write(input logic [7:0] off, input logic [7:0] val);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = off; cfg_wdata = val;
        @(posedge clk);
        #1;
        cfg_wr = 1'b0;
        if (off == 8'h59) mdl[0] = val & 8'hF0;
        else if (off >= 8'h5A && off <= 8'h5F) mdl[off - 8'h59] = val;
    endtask

    task automatic probe(input string req, input logic v, input logic wr, input logic [19:0] a);
        host_valid = v; host_write = wr; host_addr = a;
        #1;
        check(req, {30'd0, route_internal, route_external}, {30'd0, exp_route(v, wr, a)});
    endtask

    task automatic sweep(input string req);
        for (int s = 0; s < 13; s++) begin
            logic [19:0] lo, hi;
            lo = (s < 12) ? 20'hC0000 + 20'(s) * 20'h4000 : 20'hF0000;
            hi = (s < 12) ? lo + 20'h3FFF : 20'hFFFFF;
            for (int d = 0; d < 2; d++) begin
                probe(req, 1'b1, d[0], lo);
                probe(req, 1'b1, d[0], hi);
            end
        end
    endtask

    task automatic readback(input string req);
        for (int o = 8'h57; o <= 8'h61; o++) begin
            cfg_addr = 8'(o);
            #1;
            check(req, {24'd0, cfg_rdata},
                  {24'd0, (o >= 8'h59 && o <= 8'h5F) ? mdl[o - 8'h59] : 8'h00});
        end
    endtask

    task automatic t_reset;
        readback("R6 readback after reset");
        check("R6 shadow_bios after reset", {31'd0, shadow_bios}, 32'd0);
        sweep("R6 external after reset");
    endtask

    task automatic t_bios;
        cfg_write(8'h59, 8'hFF);
        readback("R2 low nibble dropped");
        check("R5 shadow_bios set", {31'd0, shadow_bios}, 32'd1);
        sweep("R4 bios internal");
        cfg_write(8'h59, 8'h2F);
        check("R5 shadow_bios clear", {31'd0, shadow_bios}, 32'd0);
        probe("R4 bios write internal", 1'b1, 1'b1, 20'hF8000);
        probe("R4 bios read external", 1'b1, 1'b0, 20'hF8000);
    endtask

    task automatic t_option;
        logic [7:0] pat [6] = '{8'h21, 8'h12, 8'h30, 8'h03, 8'hC9, 8'h6A};
        for (int k = 0; k < 6; k++) cfg_write(8'h5A + 8'(k), pat[k]);
        readback("R1 option readback");
        sweep("R3 segment map pattern A");
        for (int k = 0; k < 6; k++) cfg_write(8'h5A + 8'(k), ~pat[k]);
        sweep("R3 segment map pattern B");
    endtask

    task automatic t_outside;
        cfg_write(8'h59, 8'h30);
        for (int k = 0; k < 6; k++) cfg_write(8'h5A + 8'(k), 8'h33);
        probe("R7 below window read", 1'b1, 1'b0, 20'hBFFFF);
        probe("R7 below window write", 1'b1, 1'b1, 20'hA0000);
        probe("R7 low memory", 1'b1, 1'b0, 20'h00000);
        probe("R7 invalid access", 1'b0, 1'b0, 20'hC0000);
        probe("R7 invalid bios", 1'b0, 1'b1, 20'hFFFFF);
    endtask

    task automatic t_unmapped;
        cfg_write(8'h58, 8'hFF);
        cfg_write(8'h60, 8'hFF);
        cfg_write(8'h00, 8'hFF);
        readback("R1 unmapped writes ignored");
        sweep("R1 routing unchanged by unmapped");
    endtask

    task automatic t_timing;
        cfg_write(8'h5A, 8'h00);
        @(negedge clk);
        host_valid = 1'b1; host_write = 1'b0; host_addr = 20'hC0010;
        cfg_wr = 1'b1; cfg_addr = 8'h5A; cfg_wdata = 8'h01;
        #1;
        check("R8 old route before edge", {30'd0, route_internal, route_external}, 32'd1);
        check("R8 old readback before edge", {24'd0, cfg_rdata}, 32'h00);
        @(posedge clk);
        #1;
        cfg_wr = 1'b0;
        mdl[1] = 8'h01;
        check("R8 new route after edge", {30'd0, route_internal, route_external}, 32'd2);
        check("R8 new readback after edge", {24'd0, cfg_rdata}, 32'h01);
        host_write = 1'b1;
        #1;
        check("R8 combinational direction change", {30'd0, route_internal, route_external}, 32'd1);
    endtask

    task automatic t_reset_mid;
        cfg_write(8'h59, 8'hF0);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        for (int k = 0; k < 7; k++) mdl[k] = 8'h00;
        readback("R6 async reset clears");
        sweep("R6 external after mid reset");
        check("R6 flag after mid reset", {31'd0, shadow_bios}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        for (int k = 0; k < 7; k++) mdl[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bios();
        t_option();
        t_outside();
        t_unmapped();
        t_timing();
        t_reset_mid();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule